// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers interrupt causes from internal event sources and from software, keeps them in a cause register, and filters them through a mask register. It drives one level-sensitive interrupt line. The line is high while any cause bit is enabled by a matching mask bit. The top bit of the cause register is a summary flag. Whenever any cause is pending, the block forces it on, so software can enable one mask bit and be interrupted by any cause.

Software reaches the block through a small single-cycle register port. One address reads the cause register and clears it in the same access, and a write to that address clears the cause bits written as one. Separate addresses set cause bits, set mask bits and clear mask bits. Event sources inside the chip raise cause bits with one-cycle pulses, which go through the same set path as a software cause-set write.

Top module: `irq_ctrl`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the cause and mask registers and drives irq, rd_valid and rd_data to zero.
- R2: A write to address 1 (cause-set) ORs reg_wdata into the cause register.
- R3: After every update, bit DATA_W-1 of the cause register (the summary bit) is 1 if the result is non-zero and 0 if it is zero.
- R4: irq is registered and equals the OR of (mask AND cause) as held after the most recent clock edge.
- R5: A read (reg_rd high, reg_wr low) of address 0 puts the current cause value on rd_data with rd_valid high on the next cycle, and clears the cause register.
- R6: A write to address 0 clears each cause bit written as 1 and leaves the other bits unchanged. The summary rule R3 is then applied.
- R7: A write to address 2 (mask-set) ORs reg_wdata into the mask. A read of address 2 returns the mask.
- R8: A write to address 3 (mask-clear) clears each mask bit written as 1.
- R9: Each high bit of evt_pulse sets the cause bit at the same position, in the same cycle as and together with any software set or clear.
- R10: An event pulse in the same cycle as a cause read is kept after the clear; the read returns the value from before the event.
- R11: Reads of addresses 1 and 3 and of any address above 3 return zero. Writes to addresses above 3 change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, takes priority over reg_rd |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| evt_pulse | input | EVT_W | One-cycle cause pulses from internal sources |
| rd_data | output | DATA_W | Read data, valid with rd_valid |
| rd_valid | output | 1 | High for one cycle after an accepted read |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with DATA_W=32, EVT_W=8 and ADDR_W=3. With these values the summary bit is bit 31, so it can be masked on its own and cleared on its own. That makes the case where a write-one-to-clear leaves only the summary bit pending, and only the summary bit's mask keeps the line high, reachable and checkable. Eight event lines allow events to coincide with a read-to-clear and with software sets at distinct bit positions. Address 5 sits inside the decoded space but outside the map, so the bench uses it to check that stray accesses have no effect.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int unsigned OFS_CAUSE = 0;
  localparam int unsigned OFS_CSET  = 1;
  localparam int unsigned OFS_MSET  = 2;
  localparam int unsigned OFS_MCLR  = 3;

  typedef struct packed {
    logic rd_cause;
    logic rd_mask;
    logic w1c_cause;
    logic set_cause;
    logic set_mask;
    logic clr_mask;
  } irq_cmd_t;

endpackage

// File: rtl/irq_decode.sv
module irq_decode
  import irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output irq_cmd_t          cmd_o
);

  logic rd_acc;
  logic hit_cause, hit_cset, hit_mset, hit_mclr;

  assign rd_acc    = rd_i && !wr_i;
  assign hit_cause = (addr_i == ADDR_W'(OFS_CAUSE));
  assign hit_cset  = (addr_i == ADDR_W'(OFS_CSET));
  assign hit_mset  = (addr_i == ADDR_W'(OFS_MSET));
  assign hit_mclr  = (addr_i == ADDR_W'(OFS_MCLR));

  always_comb begin
    cmd_o           = '0;
    cmd_o.rd_cause  = rd_acc && hit_cause;
    cmd_o.rd_mask   = rd_acc && hit_mset;
    cmd_o.w1c_cause = wr_i && hit_cause;
    cmd_o.set_cause = wr_i && hit_cset;
    cmd_o.set_mask  = wr_i && hit_mset;
    cmd_o.clr_mask  = wr_i && hit_mclr;
  end

endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int DATA_W = 32,
  parameter int EVT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_clr_i,
  input  logic              w1c_i,
  input  logic              set_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [EVT_W-1:0]  evt_i,
  output logic [DATA_W-1:0] cause_q_o,
  output logic [DATA_W-1:0] cause_nxt_o
);

  localparam int SUM_BIT = DATA_W - 1;

  logic [DATA_W-1:0] evt_ext;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] cause_q;

  generate
    if (EVT_W < DATA_W - 1) begin : g_pad
      assign evt_ext = {{(DATA_W-EVT_W){1'b0}}, evt_i};
    end else begin : g_full
      assign evt_ext = {1'b0, evt_i[DATA_W-2:0]};
    end
  endgenerate

  always_comb begin
    base = rd_clr_i ? '0 : cause_q;
    if (w1c_i) base = base & ~wdata_i;
    raw = base | evt_ext;
    if (set_i) raw = raw | wdata_i;
    cause_nxt_o = raw;
    if (|raw) cause_nxt_o[SUM_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_nxt_o;
  end

  assign cause_q_o = cause_q;

  AST_SUMMARY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|cause_q[SUM_BIT-1:0]) |-> cause_q[SUM_BIT]); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && !set_i && !w1c_i && evt_i == '0) |=> (cause_q == '0)); // R5

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((cause_q[EVT_W-1:0] & $past(evt_i)) == $past(evt_i))); // R10

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> ((cause_q & $past(wdata_i)) == $past(wdata_i))); // R2

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_q_o,
  output logic [DATA_W-1:0] mask_nxt_o
);

  logic [DATA_W-1:0] mask_q;

  always_comb begin
    mask_nxt_o = mask_q;
    if (set_i) mask_nxt_o = mask_nxt_o | wdata_i;
    if (clr_i) mask_nxt_o = mask_nxt_o & ~wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_nxt_o;
  end

  assign mask_q_o = mask_q;

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i))); // R7

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((mask_q & $past(wdata_i)) == '0)); // R8

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(mask_q)); // R11

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EVT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [EVT_W-1:0]  evt_pulse,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              irq
);

  irq_cmd_t          cmd;
  logic [DATA_W-1:0] cause_q, cause_nxt;
  logic [DATA_W-1:0] mask_q, mask_nxt;
  logic [DATA_W-1:0] rd_mux;
  logic              rd_any;
  logic              irq_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q;

  irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_i   (reg_wr),
    .rd_i   (reg_rd),
    .addr_i (reg_addr),
    .cmd_o  (cmd)
  );

  irq_cause_reg #(.DATA_W(DATA_W), .EVT_W(EVT_W)) u_cause (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_clr_i    (cmd.rd_cause),
    .w1c_i       (cmd.w1c_cause),
    .set_i       (cmd.set_cause),
    .wdata_i     (reg_wdata),
    .evt_i       (evt_pulse),
    .cause_q_o   (cause_q),
    .cause_nxt_o (cause_nxt)
  );

  irq_mask_reg #(.DATA_W(DATA_W)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (cmd.set_mask),
    .clr_i      (cmd.clr_mask),
    .wdata_i    (reg_wdata),
    .mask_q_o   (mask_q),
    .mask_nxt_o (mask_nxt)
  );

  assign rd_any = reg_rd && !reg_wr;

  always_comb begin
    rd_mux = '0;
    if (cmd.rd_cause)     rd_mux = cause_q;
    else if (cmd.rd_mask) rd_mux = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q      <= 1'b0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      irq_q      <= |(mask_nxt & cause_nxt);
      rd_valid_q <= rd_any;
      if (rd_any) rd_data_q <= rd_mux;
    end
  end

  assign irq      = irq_q;
  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(mask_q & cause_q)); // R4

  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> rd_valid); // R5

  AST_RD_CAUSE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.rd_cause |=> (rd_data == $past(cause_q))); // R5

endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;

  localparam int DATA_W = 32;
  localparam int EVT_W  = 8;
  localparam int ADDR_W = 3;
  localparam int NV     = 24;
  localparam int VW     = 78;

  // fields: [77:76] op (0 idle,1 write,2 read), [75:73] addr, [72:41] data,
  // [40:33] events, [32] expected irq, [31:0] expected read data
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd2, 3'd2, 32'h0,        8'h00, 1'b0, 32'h0},        // 0  R1 R7 mask empty
    {2'd1, 3'd2, 32'h5,        8'h00, 1'b0, 32'h0},        // 1  R7 mask-set
    {2'd2, 3'd2, 32'h0,        8'h00, 1'b0, 32'h5},        // 2  R7 readback
    {2'd1, 3'd1, 32'h2,        8'h00, 1'b0, 32'h0},        // 3  R2 unmasked cause
    {2'd1, 3'd1, 32'h4,        8'h00, 1'b1, 32'h0},        // 4  R2 R4 masked cause
    {2'd2, 3'd0, 32'h0,        8'h00, 1'b0, 32'h80000006}, // 5  R3 R5 read-clear
    {2'd2, 3'd0, 32'h0,        8'h00, 1'b0, 32'h0},        // 6  R3 R5 empty
    {2'd0, 3'd0, 32'h0,        8'h01, 1'b1, 32'h0},        // 7  R9 event
    {2'd1, 3'd0, 32'h1,        8'h00, 1'b0, 32'h0},        // 8  R6 R3 summary stays
    {2'd1, 3'd2, 32'h80000000, 8'h00, 1'b1, 32'h0},        // 9  R4 summary masked
    {2'd1, 3'd0, 32'h80000000, 8'h00, 1'b0, 32'h0},        // 10 R6 clear summary
    {2'd1, 3'd1, 32'h10,       8'h00, 1'b1, 32'h0},        // 11 R3 R4
    {2'd1, 3'd3, 32'h80000000, 8'h00, 1'b0, 32'h0},        // 12 R8 mask-clear
    {2'd2, 3'd2, 32'h0,        8'h00, 1'b0, 32'h5},        // 13 R8 readback
    {2'd2, 3'd3, 32'h0,        8'h00, 1'b0, 32'h0},        // 14 R11 reads zero
    {2'd2, 3'd1, 32'h0,        8'h00, 1'b0, 32'h0},        // 15 R11 reads zero
    {2'd2, 3'd0, 32'h0,        8'h04, 1'b1, 32'h80000010}, // 16 R10 event kept
    {2'd2, 3'd0, 32'h0,        8'h00, 1'b0, 32'h80000004}, // 17 R10 R5
    {2'd1, 3'd1, 32'h1,        8'h02, 1'b1, 32'h0},        // 18 R9 event with set
    {2'd1, 3'd3, 32'h5,        8'h00, 1'b0, 32'h0},        // 19 R8
    {2'd1, 3'd5, 32'hFFFFFFFF, 8'h00, 1'b0, 32'h0},        // 20 R11 stray write
    {2'd2, 3'd5, 32'h0,        8'h00, 1'b0, 32'h0},        // 21 R11 stray read
    {2'd2, 3'd2, 32'h0,        8'h00, 1'b0, 32'h0},        // 22 R11 mask untouched
    {2'd2, 3'd0, 32'h0,        8'h00, 1'b0, 32'h80000003}  // 23 R9 R11 cause
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [EVT_W-1:0]  evt_pulse = '0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid;
  logic              irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  irq_ctrl #(.DATA_W(DATA_W), .EVT_W(EVT_W), .ADDR_W(ADDR_W)) i_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .evt_pulse (evt_pulse),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input logic [EVT_W-1:0] e);
    reg_wr    = (op == 2'd1);
    reg_rd    = (op == 2'd2);
    reg_addr  = a;
    reg_wdata = d;
    evt_pulse = e;
    @(posedge clk);
    @(negedge clk);
    reg_wr    = 1'b0;
    reg_rd    = 1'b0;
    evt_pulse = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while held in reset
    check("R1 irq in reset", {31'b0, irq}, 32'h0);
    check("R1 rd_valid in reset", {31'b0, rd_valid}, 32'h0);
    check("R1 rd_data in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[77:76], v[75:73], v[72:41], v[40:33]);
      check($sformatf("vector %0d irq (R4)", i), {31'b0, irq}, {31'b0, v[32]});
      if (v[77:76] == 2'd2) begin
        check($sformatf("vector %0d rd_valid (R5)", i), {31'b0, rd_valid}, 32'h1);
        check($sformatf("vector %0d rd_data", i), rd_data, v[31:0]);
      end
    end

    // R1: reset in mid-run clears pending cause and mask
    step(2'd1, 3'd2, 32'h1, 8'h00);
    step(2'd1, 3'd1, 32'h1, 8'h00);
    check("R4 irq before reset", {31'b0, irq}, 32'h1);
    rst_n = 1'b0;
    #1;
    check("R1 irq after async reset", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step(2'd2, 3'd2, 32'h0, 8'h00);
    check("R1 mask after reset", rd_data, 32'h0);
    step(2'd2, 3'd0, 32'h0, 8'h00);
    check("R1 cause after reset", rd_data, 32'h0);

    // R6 R3: W1C of every bit but the summary leaves the summary pending
    step(2'd0, 3'd0, 32'h0, 8'h81);
    step(2'd1, 3'd0, 32'h00000081, 8'h00);
    step(2'd2, 3'd0, 32'h0, 8'h00);
    check("R6 R3 summary after w1c", rd_data, 32'h80000000);

    // R5: rd_valid drops on the cycle after a single read
    step(2'd0, 3'd0, 32'h0, 8'h00);
    check("R5 rd_valid one cycle", {31'b0, rd_valid}, 32'h0);

    finish_run();
  end

endmodule